// File: doc/BRIEF.md
# Prioritized Interrupt Level Dispatcher

This block sits beside a processor's exception logic and decides, on a request strobe, whether an interrupt pending at a given priority level may be taken. A level is taken only when three things hold. It must lie above the level the status word currently masks. It must be within the configured number of levels. At least one of its source lines must be both raised and enabled. When the level is taken, the block commits the whole entry sequence in one clock edge. It banks the PC and the status word, rewrites the status word and selects the next PC.

Levels of two and above are high-priority. Each has its own saved-PC and saved-status register and its own vector. Level 1 is handled differently: it is turned into a general exception. The kind of exception depends on two bits of the status word. If the exception-mode bit is set, the result is a double exception. Otherwise the user-mode bit chooses between a user exception and a kernel exception. Every vector may be relocated by a vector-base register.

A small state machine reports the outcome for one cycle after each strobe. It has four states: `ST_IDLE`, `ST_HIGH_DONE`, `ST_EXC_DONE` and `ST_REJECT_DONE`. Each strobe moves it from any state according to the decision. An accepted high level goes to `ST_HIGH_DONE`. An accepted level 1 goes to `ST_EXC_DONE`. A rejected request goes to `ST_REJECT_DONE`. A cycle with no strobe returns it to `ST_IDLE`.

Top module: `irq_level_dispatch`

## Requirements
- R1: A request at level L is accepted only if all of these hold: L is strictly greater than `ps_in[3:0]`; L is no greater than `cfg_max_level`; L is between 1 and NLEVELS (6); and `lvl_mask[(L-1)*32 +: 32] & int_set & int_en` is nonzero.
- R2: After a rejected request, `taken` is low in the next cycle. In that cycle `ps_out` equals the sampled `ps_in` and `next_pc` equals the sampled `pc_in`. The saved-PC, saved-status, `depc` and `cause` outputs keep their values.
- R3: Accepting level L≥2 loads `pc_in` into `epc_flat[(L-1)*32 +: 32]` and loads `ps_in` into `eps_flat[(L-2)*32 +: 32]`.
- R4: Accepting level L≥2 gives a `ps_out` that equals `ps_in` with bits [3:0] replaced by L and the exception-mode bit (bit 4) set.
- R5: Accepting level L≥2 sets `next_pc` to the level-L vector and reports `exc_kind` = 4.
- R6: Accepting level 1 loads `cause` with 4. A high level leaves `cause` unchanged.
- R7: Accepting level 1 while `ps_in[4]` is set reports `exc_kind` = 3 (double) and loads `pc_in` into `depc`. In this case the level-1 saved-PC is left unchanged.
- R8: Accepting level 1 while `ps_in[4]` is clear loads `pc_in` into the level-1 saved-PC. It reports `exc_kind` = 1 (user) if `ps_in[5]` is set, and 2 (kernel) otherwise.
- R9: Accepting level 1 gives `ps_out` = `ps_in` with bit 4 set. It sets `next_pc` to the kernel, user or double vector, according to `exc_kind`.
- R10: With relocation on, each vector is `vecbase` plus its offset. The offsets are 0x40·L for level L, 0x300 for kernel, 0x340 for user and 0x3C0 for double. This is the same as the default address (default base 0x4000_0000 plus the offset), minus the default base, plus `vecbase`.
- R11: After reset every output is zero. `taken` is high only in the cycle after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe; decision and commit happen at this edge |
| pend_level | input | 4 | Priority level of the pending interrupt |
| cfg_max_level | input | 4 | Configured highest usable level |
| lvl_mask | input | 192 | Source mask per level, level L at bits (L-1)*32 +: 32 |
| int_set | input | 32 | Raised interrupt lines |
| int_en | input | 32 | Enabled interrupt lines |
| ps_in | input | 32 | Current status word; bits [3:0] hold the interrupt level |
| pc_in | input | 32 | Current program counter |
| vecbase | input | 32 | Vector-base register |
| taken | output | 1 | High for one cycle after an accepted request |
| exc_kind | output | 3 | 0 none, 1 user, 2 kernel, 3 double, 4 high level |
| ps_out | output | 32 | Status word after the request |
| next_pc | output | 32 | PC after the request |
| epc_flat | output | 192 | Saved-PC registers, level L at (L-1)*32 |
| eps_flat | output | 160 | Saved-status registers, level L≥2 at (L-2)*32 |
| depc | output | 32 | Double-exception saved PC |
| cause | output | 6 | Exception cause register |

## Verification
All internal state is visible at the ports one cycle after the strobe. A wrong state-machine state shows as `taken` or `exc_kind` disagreeing with the decision in that same cycle. A bank write to the wrong level shows as a saved register changing that the request should not have touched. The directed scenarios compare every banked register, not only the one that was targeted. They use boundary levels (equal to the current level, and at or above the configured maximum) and a masked-off source, so that an off-by-one in the acceptance test appears in the very next cycle.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_USER   = 3'd1,
        KIND_KERNEL = 3'd2,
        KIND_DOUBLE = 3'd3,
        KIND_HIGH   = 3'd4
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH_DONE,
        ST_EXC_DONE,
        ST_REJECT_DONE
    } disp_state_e;

    localparam int          XLEN         = 32;
    localparam int          CAUSE_W      = 6;
    localparam logic [5:0]  CAUSE_L1_IRQ = 6'd4;
    localparam logic [31:0] VEC_STRIDE   = 32'h40;
    localparam logic [31:0] OFF_KERNEL   = 32'h300;
    localparam logic [31:0] OFF_USER     = 32'h340;
    localparam logic [31:0] OFF_DOUBLE   = 32'h3C0;

endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
    parameter int NLEVELS = 6,
    parameter int NINT    = 32,
    parameter int LW      = 4
) (
    input  logic [LW-1:0]           pend_level,
    input  logic [LW-1:0]           cur_level,
    input  logic [LW-1:0]           max_level,
    input  logic [NLEVELS*NINT-1:0] mask_flat,
    input  logic [NINT-1:0]         int_set,
    input  logic [NINT-1:0]         int_en,
    output logic                    accept
);
    logic [NINT-1:0] sel_mask;
    logic            in_range;

    // pick the source mask of the pending level
    always_comb begin
        sel_mask = '0;
        for (int i = 1; i <= NLEVELS; i++) begin
            if (pend_level == LW'(i)) sel_mask = mask_flat[(i-1)*NINT +: NINT];
        end
    end

    assign in_range = (pend_level != '0) && (int'(pend_level) <= NLEVELS);
    assign accept   = in_range && (pend_level > cur_level) &&
                      (pend_level <= max_level) && (|(sel_mask & int_set & int_en));

endmodule

// File: rtl/irq_vector.sv
module irq_vector
    import irq_disp_pkg::*;
#(
    parameter int          LW       = 4,
    parameter bit          RELOC    = 1'b1,
    parameter logic [31:0] DEF_BASE = 32'h4000_0000
) (
    input  logic [LW-1:0] level,
    input  exc_kind_e     kind,
    input  logic [31:0]   vecbase,
    output logic [31:0]   vec
);
    logic [31:0] offset;

    always_comb begin
        unique case (kind)
            KIND_HIGH:   offset = 32'(level) * VEC_STRIDE;
            KIND_USER:   offset = OFF_USER;
            KIND_KERNEL: offset = OFF_KERNEL;
            KIND_DOUBLE: offset = OFF_DOUBLE;
            default:     offset = '0;
        endcase
    end

    // default - DEF_BASE + vecbase reduces to offset + vecbase
    generate
        if (RELOC) begin : g_reloc
            assign vec = vecbase + offset;
        end else begin : g_fixed
            logic unused_vb;
            assign unused_vb = ^vecbase;
            assign vec = DEF_BASE + offset;
        end
    endgenerate

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_disp_pkg::*;
#(
    parameter int NLEVELS  = 6,
    parameter int LW       = 4,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      accept,
    input  logic                      hi_wr,
    input  logic                      l1_wr,
    input  logic                      dbl,
    input  logic [LW-1:0]             lvl,
    input  logic [XLEN-1:0]           pc_in,
    input  logic [XLEN-1:0]           ps_in,
    input  logic [XLEN-1:0]           ps_new,
    input  logic [XLEN-1:0]           npc_new,
    output logic [XLEN-1:0]           ps_q,
    output logic [XLEN-1:0]           npc_q,
    output logic [NLEVELS*XLEN-1:0]   epc_flat,
    output logic [(NLEVELS-1)*XLEN-1:0] eps_flat,
    output logic [XLEN-1:0]           depc_q,
    output logic [CAUSE_W-1:0]        cause_q
);
    localparam bit DBL_TO_DEPC = HAS_DEPC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q  <= '0;
            npc_q <= '0;
        end else if (req) begin
            ps_q  <= accept ? ps_new  : ps_in;
            npc_q <= accept ? npc_new : pc_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cause_q <= '0;
        else if (l1_wr) cause_q <= CAUSE_L1_IRQ;
    end

    generate
        for (genvar i = 0; i < NLEVELS; i++) begin : g_epc
            logic wr;
            if (i == 0) begin : g_l1
                assign wr = (hi_wr && lvl == LW'(1)) || (l1_wr && !(dbl && DBL_TO_DEPC));
            end else begin : g_hi
                assign wr = hi_wr && (lvl == LW'(i + 1));
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  epc_flat[i*XLEN +: XLEN] <= '0;
                else if (wr) epc_flat[i*XLEN +: XLEN] <= pc_in;
            end
        end

        for (genvar j = 0; j < NLEVELS - 1; j++) begin : g_eps
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) eps_flat[j*XLEN +: XLEN] <= '0;
                else if (hi_wr && lvl == LW'(j + 2)) eps_flat[j*XLEN +: XLEN] <= ps_in;
            end
        end

        if (HAS_DEPC) begin : g_depc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            depc_q <= '0;
                else if (l1_wr && dbl) depc_q <= pc_in;
            end
        end else begin : g_no_depc
            assign depc_q = '0;
        end
    endgenerate

endmodule

// File: rtl/irq_level_dispatch.sv
module irq_level_dispatch
    import irq_disp_pkg::*;
#(
    parameter int          NLEVELS  = 6,
    parameter int          NINT     = 32,
    parameter int          LW       = 4,
    parameter int          EXCM_BIT = 4,
    parameter int          UM_BIT   = 5,
    parameter bit          HAS_DEPC = 1'b1,
    parameter bit          RELOC    = 1'b1,
    parameter logic [31:0] DEF_BASE = 32'h4000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic [LW-1:0]                 pend_level,
    input  logic [LW-1:0]                 cfg_max_level,
    input  logic [NLEVELS*NINT-1:0]       lvl_mask,
    input  logic [NINT-1:0]               int_set,
    input  logic [NINT-1:0]               int_en,
    input  logic [31:0]                   ps_in,
    input  logic [31:0]                   pc_in,
    input  logic [31:0]                   vecbase,
    output logic                          taken,
    output logic [2:0]                    exc_kind,
    output logic [31:0]                   ps_out,
    output logic [31:0]                   next_pc,
    output logic [NLEVELS*32-1:0]         epc_flat,
    output logic [(NLEVELS-1)*32-1:0]     eps_flat,
    output logic [31:0]                   depc,
    output logic [5:0]                    cause
);
    localparam logic [31:0] EXCM_MASK = 32'h1 << EXCM_BIT;

    disp_state_e state_q, state_d;
    exc_kind_e   kind_d, kind_q;
    logic        accept, is_high, hi_wr, l1_wr;
    logic [31:0] ps_new, vec;

    irq_accept #(.NLEVELS(NLEVELS), .NINT(NINT), .LW(LW)) accept_i (
        .pend_level (pend_level),
        .cur_level  (ps_in[LW-1:0]),
        .max_level  (cfg_max_level),
        .mask_flat  (lvl_mask),
        .int_set    (int_set),
        .int_en     (int_en),
        .accept     (accept)
    );

    assign is_high = pend_level >= LW'(2);
    assign hi_wr   = req && accept && is_high;
    assign l1_wr   = req && accept && !is_high;

    always_comb begin
        if (!accept)              kind_d = KIND_NONE;
        else if (is_high)         kind_d = KIND_HIGH;
        else if (ps_in[EXCM_BIT]) kind_d = KIND_DOUBLE;
        else if (ps_in[UM_BIT])   kind_d = KIND_USER;
        else                      kind_d = KIND_KERNEL;
    end

    always_comb begin
        if (is_high) ps_new = {ps_in[31:LW], pend_level} | EXCM_MASK;
        else         ps_new = ps_in | EXCM_MASK;
    end

    irq_vector #(.LW(LW), .RELOC(RELOC), .DEF_BASE(DEF_BASE)) vector_i (
        .level   (pend_level),
        .kind    (kind_d),
        .vecbase (vecbase),
        .vec     (vec)
    );

    irq_bank #(.NLEVELS(NLEVELS), .LW(LW), .HAS_DEPC(HAS_DEPC)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .accept   (accept),
        .hi_wr    (hi_wr),
        .l1_wr    (l1_wr),
        .dbl      (ps_in[EXCM_BIT]),
        .lvl      (pend_level),
        .pc_in    (pc_in),
        .ps_in    (ps_in),
        .ps_new   (ps_new),
        .npc_new  (vec),
        .ps_q     (ps_out),
        .npc_q    (next_pc),
        .epc_flat (epc_flat),
        .eps_flat (eps_flat),
        .depc_q   (depc),
        .cause_q  (cause)
    );

    // next-state logic: every state reacts to a strobe the same way
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIGH_DONE, ST_EXC_DONE, ST_REJECT_DONE: begin
                if (req) begin
                    if (!accept)     state_d = ST_REJECT_DONE;
                    else if (is_high) state_d = ST_HIGH_DONE;
                    else             state_d = ST_EXC_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
        end else begin
            state_q <= state_d;
            if (req) kind_q <= kind_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HIGH_DONE, ST_EXC_DONE: begin
                taken    = 1'b1;
                exc_kind = kind_q;
            end
            default: begin
                taken    = 1'b0;
                exc_kind = KIND_NONE;
            end
        endcase
    end

endmodule

// File: rtl/irq_level_dispatch_chk.sv
module irq_level_dispatch_chk #(
    parameter int LW       = 4,
    parameter int EXCM_BIT = 4,
    parameter int UM_BIT   = 5,
    parameter bit HAS_DEPC = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [LW-1:0] pend_level,
    input logic [31:0]   ps_in,
    input logic [31:0]   pc_in,
    input logic          taken,
    input logic [2:0]    exc_kind,
    input logic [31:0]   ps_out,
    input logic [31:0]   next_pc,
    input logic [31:0]   depc,
    input logic [5:0]    cause
);
    p_taken_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> $past(req));

    p_reject_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) && !taken) |-> (ps_out == $past(ps_in) && next_pc == $past(pc_in)
                                    && cause == $past(cause)));

    p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ps_out[EXCM_BIT]);

    p_high_level_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_kind == 3'd4) |-> ps_out[LW-1:0] == $past(pend_level));

    p_l1_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_kind != 3'd4) |-> cause == 6'd4);

    p_user_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_kind == 3'd1) |-> ($past(ps_in[UM_BIT]) && !$past(ps_in[EXCM_BIT])));

    p_double_depc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DEPC && taken && exc_kind == 3'd3) |-> depc == $past(pc_in));

endmodule

bind irq_level_dispatch irq_level_dispatch_chk #(
    .LW(LW), .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT), .HAS_DEPC(HAS_DEPC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .pend_level (pend_level),
    .ps_in      (ps_in),
    .pc_in      (pc_in),
    .taken      (taken),
    .exc_kind   (exc_kind),
    .ps_out     (ps_out),
    .next_pc    (next_pc),
    .depc       (depc),
    .cause      (cause)
);

// File: tb/irq_level_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_level_dispatch_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [3:0]   pend_level = '0;
    logic [3:0]   cfg_max_level = 4'd6;
    logic [191:0] lvl_mask = '0;
    logic [31:0]  int_set = '1;
    logic [31:0]  int_en = '1;
    logic [31:0]  ps_in = '0;
    logic [31:0]  pc_in = '0;
    logic [31:0]  vecbase = 32'h2000_0000;
    logic         taken;
    logic [2:0]   exc_kind;
    logic [31:0]  ps_out, next_pc, depc;
    logic [191:0] epc_flat;
    logic [159:0] eps_flat;
    logic [5:0]   cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    irq_level_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .pend_level(pend_level),
        .cfg_max_level(cfg_max_level), .lvl_mask(lvl_mask), .int_set(int_set),
        .int_en(int_en), .ps_in(ps_in), .pc_in(pc_in), .vecbase(vecbase),
        .taken(taken), .exc_kind(exc_kind), .ps_out(ps_out), .next_pc(next_pc),
        .epc_flat(epc_flat), .eps_flat(eps_flat), .depc(depc), .cause(cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] epc_of(input int lvl);
        return epc_flat[(lvl-1)*32 +: 32];
    endfunction

    function automatic logic [31:0] eps_of(input int lvl);
        return eps_flat[(lvl-2)*32 +: 32];
    endfunction

    // strobe for one cycle; outputs are sampled at the following negedge
    task automatic strobe(input logic [3:0] lvl, input logic [31:0] ps, input logic [31:0] pc);
        @(negedge clk);
        pend_level = lvl; ps_in = ps; pc_in = pc; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 taken after reset", 32'(taken), 32'h0);
        check("R11 ps_out after reset", ps_out, 32'h0);
        check("R11 next_pc after reset", next_pc, 32'h0);
        check("R11 cause after reset", 32'(cause), 32'h0);
        check("R11 depc after reset", depc, 32'h0);
    endtask

    task automatic t_high_accept();
        strobe(4'd3, 32'hA500_0021, 32'h1000_0100);
        check("R1 high taken", 32'(taken), 32'h1);
        check("R5 high kind", 32'(exc_kind), 32'h4);
        check("R3 epc3", epc_of(3), 32'h1000_0100);
        check("R3 eps3", eps_of(3), 32'hA500_0021);
        check("R4 ps_out high", ps_out, 32'hA500_0033);
        check("R10 R5 high vector", next_pc, 32'h2000_00C0);
        check("R6 cause untouched by high", 32'(cause), 32'h0);
        check("R3 epc1 untouched", epc_of(1), 32'h0);
        @(negedge clk);
        check("R11 taken single pulse", 32'(taken), 32'h0);
    endtask

    task automatic t_reject_equal();
        strobe(4'd3, 32'h0000_0003, 32'h1111_2222);
        check("R1 equal level rejected", 32'(taken), 32'h0);
        check("R2 ps pass-through", ps_out, 32'h0000_0003);
        check("R2 pc pass-through", next_pc, 32'h1111_2222);
        check("R2 epc3 held", epc_of(3), 32'h1000_0100);
        check("R2 eps3 held", eps_of(3), 32'hA500_0021);
    endtask

    task automatic t_reject_max();
        cfg_max_level = 4'd4;
        strobe(4'd5, 32'h0, 32'h1234_5678);
        check("R1 above max rejected", 32'(taken), 32'h0);
        check("R2 epc5 held", epc_of(5), 32'h0);
        check("R2 eps5 held", eps_of(5), 32'h0);
        strobe(4'd4, 32'h0, 32'h0000_4444);
        check("R1 at max accepted", 32'(taken), 32'h1);
        check("R3 epc4", epc_of(4), 32'h0000_4444);
        check("R10 level4 vector", next_pc, 32'h2000_0100);
        cfg_max_level = 4'd6;
    endtask

    task automatic t_reject_mask();
        int_en = ~(32'h1 << 6);
        strobe(4'd6, 32'h0, 32'h6666_0000);
        check("R1 masked source rejected", 32'(taken), 32'h0);
        check("R2 epc6 held", epc_of(6), 32'h0);
        int_en = '1;
        strobe(4'd7, 32'h0, 32'h7777_0000);
        check("R1 beyond NLEVELS rejected", 32'(taken), 32'h0);
    endtask

    task automatic t_l1_kernel();
        strobe(4'd1, 32'h0, 32'h3000_0040);
        check("R8 kernel kind", 32'(exc_kind), 32'h2);
        check("R8 epc1", epc_of(1), 32'h3000_0040);
        check("R6 cause", 32'(cause), 32'h4);
        check("R9 ps_out kernel", ps_out, 32'h0000_0010);
        check("R9 kernel vector", next_pc, 32'h2000_0300);
    endtask

    task automatic t_l1_user();
        strobe(4'd1, 32'h0000_0020, 32'h3000_0080);
        check("R8 user kind", 32'(exc_kind), 32'h1);
        check("R8 epc1 user", epc_of(1), 32'h3000_0080);
        check("R9 ps_out user", ps_out, 32'h0000_0030);
        check("R9 user vector", next_pc, 32'h2000_0340);
    endtask

    task automatic t_l1_double();
        vecbase = 32'h0800_0000;
        strobe(4'd1, 32'h0000_0030, 32'h3000_00C0);
        check("R7 double kind", 32'(exc_kind), 32'h3);
        check("R7 depc", depc, 32'h3000_00C0);
        check("R7 epc1 held", epc_of(1), 32'h3000_0080);
        check("R9 ps_out double", ps_out, 32'h0000_0030);
        check("R10 double vector relocated", next_pc, 32'h0800_03C0);
        check("R6 cause double", 32'(cause), 32'h4);
    endtask

    initial begin
        for (int l = 1; l <= 6; l++) lvl_mask[(l-1)*32 +: 32] = 32'h1 << l;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high_accept();
        t_reject_equal();
        t_reject_max();
        t_reject_mask();
        t_l1_kernel();
        t_l1_user();
        t_l1_double();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule